// File: doc/BRIEF.md
# Buffered PWM channel generator

This block produces one pulse-width-modulated output. The input clock is slowed by a power-of-two prescaler, and a period counter then counts the prescaled ticks. Every period opens at the inactive level. The output turns active once the counter reaches the stored duty count. The duty count therefore gives the length of the inactive part, and the active part lasts for the period count minus the duty count. A polarity bit selects which logic level is the active one.

While the channel is stopped, a configuration strobe loads the period, duty, prescaler exponent and polarity directly. While it runs, a new duty value enters through an update strobe. That value is held in a shadow register, and an update-pending flag stays high until the period ends. At the period boundary the shadow value is copied into the live duty register. The current period is never disturbed. A period-start pulse marks each boundary, so a register block can turn it into an interrupt.

Top module: `bufpwm_channel`

## Requirements
- R1: During and just after reset the output is low (reset polarity is active-high), the update-pending flag is low and no period-start pulse appears.
- R2: The period counter advances once every 2^N input clocks, where N is the 4-bit exponent. Exponent values 11 to 15 act as 10.
- R3: A period lasts P prescaled ticks (a period value of 0 acts as 1). The output is inactive for the first D ticks and active for the remaining P-D ticks.
- R4: Polarity bit 1 makes the active level high and polarity bit 0 makes it low. While the enable input is low the output sits at the inactive level.
- R5: A duty value of 0 gives an output that is active for the whole period. A duty value equal to or greater than the period value gives an output that is inactive for the whole period.
- R6: The period-start output is high for exactly the last input clock of each period while enabled. It is never high while disabled.
- R7: An update strobe while enabled stores the value in the shadow and raises the pending flag from the next cycle. At a boundary with no coincident update strobe, the shadow value becomes the live duty and the pending flag falls. An update strobe that coincides with a boundary stays pending until the following boundary.
- R8: A duty update made in mid-period leaves the remainder of that period unchanged.
- R9: While disabled, the configuration strobe loads period, duty, exponent and polarity, and the update strobe loads the live duty directly. If both strobes arrive together, the update strobe's duty wins. While disabled, a pending shadow value is applied and the flag clears. While enabled, the configuration strobe is ignored.
- R10: While disabled, the prescaler and period counter are held at zero, so the first period after enabling has its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Channel run enable |
| cfg_wr | input | 1 | Configuration load strobe (honoured only while disabled) |
| cfg_period | input | DATA_W | Period count in prescaled ticks |
| cfg_duty | input | DATA_W | Inactive-part count in prescaled ticks |
| cfg_exp | input | 4 | Prescaler exponent N |
| cfg_pol | input | 1 | 1 = active high, 0 = active low |
| upd_wr | input | 1 | Duty update strobe |
| upd_duty | input | DATA_W | New duty value for the update |
| pwm_out | output | 1 | Waveform |
| period_start | output | 1 | Pulse in the last clock of each period |
| upd_pending | output | 1 | A shadowed duty value awaits the next boundary |

## Verification
Some properties are checked on every cycle. These are: the inactive output level and the absence of period-start pulses while disabled, the counters held at zero while disabled, the live duty staying stable between boundaries while running, and the pending flag being set by an update and cleared at a boundary. Other behaviour only shows over whole periods, so the bench scenarios have to cover it. This includes the waveform shape across periods, the exponent clamp, the duty extremes and the untouched waveform after a mid-period update. It also includes the rule that configuration writes are ignored while running. The bench measures those by counting period lengths and active cycles, and it compares every cycle against a behavioural model.

// File: rtl/bufpwm_pkg.sv
package bufpwm_pkg;

    localparam int EXP_W   = 4;
    localparam int EXP_MAX = 10;
    localparam int PRE_W   = EXP_MAX;

    typedef logic [EXP_W-1:0] exp_t;
    typedef logic [PRE_W-1:0] pre_t;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } level_e;

    typedef struct packed {
        exp_t   exp;
        level_e act_lvl;
    } mode_t;

    function automatic exp_t clamp_exp(exp_t e);
        return (e > exp_t'(EXP_MAX)) ? exp_t'(EXP_MAX) : e;
    endfunction

    // Prescaler terminal mask; for the top exponent the shift wraps to
    // zero and the subtraction yields all ones, which is the intended mask.
    function automatic pre_t tick_mask(exp_t e);
        return (pre_t'(1) << e) - pre_t'(1);
    endfunction

    function automatic logic drive_level(logic active, level_e lvl);
        return active ? logic'(lvl) : ~logic'(lvl);
    endfunction

endpackage

// File: rtl/bufpwm_prescaler.sv
module bufpwm_prescaler
    import bufpwm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  exp_t exp_lvl,
    output logic tick,
    output pre_t pre_cnt
);
    pre_t mask;

    assign mask = tick_mask(exp_lvl);
    assign tick = en && ((pre_cnt & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !en)
            pre_cnt <= '0;
        else if (tick)
            pre_cnt <= '0;
        else
            pre_cnt <= pre_cnt + pre_t'(1);
    end
endmodule

// File: rtl/bufpwm_period_ctr.sv
module bufpwm_period_ctr #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tick,
    input  logic [DATA_W-1:0] period,
    output logic [DATA_W-1:0] cnt,
    output logic              last
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic [DATA_W-1:0] final_idx;

    assign final_idx = (period == '0) ? '0 : period - ONE;
    assign last      = tick && (cnt >= final_idx);

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt <= '0;
        else if (last)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + ONE;
    end
endmodule

// File: rtl/bufpwm_duty_buf.sv
module bufpwm_duty_buf #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              boundary,
    input  logic              cfg_wr,
    input  logic [DATA_W-1:0] cfg_duty,
    input  logic              upd_wr,
    input  logic [DATA_W-1:0] upd_duty,
    output logic [DATA_W-1:0] duty_live,
    output logic              pending
);
    logic [DATA_W-1:0] shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_live <= '0;
            shadow    <= '0;
            pending   <= 1'b0;
        end else if (!en) begin
            pending <= 1'b0;
            if (upd_wr)
                duty_live <= upd_duty;
            else if (cfg_wr)
                duty_live <= cfg_duty;
            else if (pending)
                duty_live <= shadow;
        end else begin
            if (boundary && pending)
                duty_live <= shadow;
            if (upd_wr) begin
                shadow  <= upd_duty;
                pending <= 1'b1;
            end else if (boundary) begin
                pending <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/bufpwm_channel.sv
module bufpwm_channel
    import bufpwm_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              cfg_wr,
    input  logic [DATA_W-1:0] cfg_period,
    input  logic [DATA_W-1:0] cfg_duty,
    input  logic [3:0]        cfg_exp,
    input  logic              cfg_pol,
    input  logic              upd_wr,
    input  logic [DATA_W-1:0] upd_duty,
    output logic              pwm_out,
    output logic              period_start,
    output logic              upd_pending
);
    logic [DATA_W-1:0] period_q;
    mode_t             mode_q;
    logic              tick;
    pre_t              pre_cnt;
    logic [DATA_W-1:0] cnt;
    logic              last;
    logic [DATA_W-1:0] duty_live;
    logic              active;

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q       <= '0;
            mode_q.exp     <= '0;
            mode_q.act_lvl <= LVL_HIGH;
        end else if (!en && cfg_wr) begin
            period_q       <= cfg_period;
            mode_q.exp     <= clamp_exp(cfg_exp);
            mode_q.act_lvl <= level_e'(cfg_pol);
        end
    end

    bufpwm_prescaler u_pre (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .exp_lvl (mode_q.exp),
        .tick    (tick),
        .pre_cnt (pre_cnt)
    );

    bufpwm_period_ctr #(.DATA_W(DATA_W)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .tick   (tick),
        .period (period_q),
        .cnt    (cnt),
        .last   (last)
    );

    bufpwm_duty_buf #(.DATA_W(DATA_W)) u_duty (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .boundary  (last),
        .cfg_wr    (cfg_wr),
        .cfg_duty  (cfg_duty),
        .upd_wr    (upd_wr),
        .upd_duty  (upd_duty),
        .duty_live (duty_live),
        .pending   (upd_pending)
    );

    assign active       = en && (cnt >= duty_live);
    assign pwm_out      = drive_level(active, mode_q.act_lvl);
    assign period_start = last;
endmodule

// File: rtl/bufpwm_checker.sv
module bufpwm_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              upd_wr,
    input logic              period_start,
    input logic              upd_pending,
    input logic              pwm_out,
    input logic              act_lvl,
    input logic [DATA_W-1:0] duty_live,
    input logic [DATA_W-1:0] cnt,
    input logic [9:0]        pre_cnt
);
    assert_off_level_R4: assert property (@(posedge clk) disable iff (rst)
        !en |-> (pwm_out == !act_lvl));

    assert_no_start_off_R6: assert property (@(posedge clk) disable iff (rst)
        !en |-> !period_start);

    assert_pend_set_R7: assert property (@(posedge clk) disable iff (rst)
        (en && upd_wr) |=> upd_pending);

    assert_pend_drop_R7: assert property (@(posedge clk) disable iff (rst)
        (en && period_start && !upd_wr) |=> !upd_pending);

    assert_duty_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (en && !period_start) |=> $stable(duty_live));

    assert_off_nopend_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> !upd_pending);

    assert_off_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == '0 && pre_cnt == '0));
endmodule

bind bufpwm_channel bufpwm_checker #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .en           (en),
    .upd_wr       (upd_wr),
    .period_start (period_start),
    .upd_pending  (upd_pending),
    .pwm_out      (pwm_out),
    .act_lvl      (mode_q.act_lvl),
    .duty_live    (duty_live),
    .cnt          (cnt),
    .pre_cnt      (pre_cnt)
);

// File: tb/bufpwm_channel_test.sv
`timescale 1ns/1ps
module bufpwm_channel_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic         cfg_wr = 1'b0;
    logic [W-1:0] cfg_period = '0;
    logic [W-1:0] cfg_duty = '0;
    logic [3:0]   cfg_exp = '0;
    logic         cfg_pol = 1'b1;
    logic         upd_wr = 1'b0;
    logic [W-1:0] upd_duty = '0;
    logic         pwm_out, period_start, upd_pending;

    int checks = 0;
    int fails = 0;

    bufpwm_channel #(.DATA_W(W)) uut (
        .clk(clk), .rst(rst), .en(en), .cfg_wr(cfg_wr),
        .cfg_period(cfg_period), .cfg_duty(cfg_duty), .cfg_exp(cfg_exp),
        .cfg_pol(cfg_pol), .upd_wr(upd_wr), .upd_duty(upd_duty),
        .pwm_out(pwm_out), .period_start(period_start), .upd_pending(upd_pending)
    );

    always #4 clk = ~clk;

    // behavioural model of the requirements
    int m_pc, m_cnt, m_per, m_duty, m_sh, m_exp;
    logic m_pend, m_pol;

    function automatic int f_span();
        return 1 << m_exp;
    endfunction
    function automatic logic f_tick();
        return en && ((m_pc % f_span()) == f_span() - 1);
    endfunction
    function automatic logic f_last();
        int pe;
        pe = (m_per == 0) ? 1 : m_per;
        return f_tick() && (m_cnt >= pe - 1);
    endfunction
    function automatic logic f_out();
        if (!en) return !m_pol;
        return (m_cnt >= m_duty) ? m_pol : !m_pol;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_pc <= 0; m_cnt <= 0; m_per <= 0; m_duty <= 0; m_sh <= 0;
            m_exp <= 0; m_pend <= 1'b0; m_pol <= 1'b1;
        end else if (!en) begin
            m_pc <= 0; m_cnt <= 0; m_pend <= 1'b0;
            if (cfg_wr) begin
                m_per <= int'(cfg_period);
                m_exp <= (cfg_exp > 4'd10) ? 10 : int'(cfg_exp);
                m_pol <= cfg_pol;
            end
            if (upd_wr) m_duty <= int'(upd_duty);
            else if (cfg_wr) m_duty <= int'(cfg_duty);
            else if (m_pend) m_duty <= m_sh;
        end else begin
            m_pc <= f_tick() ? 0 : m_pc + 1;
            if (f_last()) m_cnt <= 0;
            else if (f_tick()) m_cnt <= m_cnt + 1;
            if (f_last() && m_pend) m_duty <= m_sh;
            if (upd_wr) begin
                m_sh <= int'(upd_duty); m_pend <= 1'b1;
            end else if (f_last()) begin
                m_pend <= 1'b0;
            end
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-period measurements
    int act_acc = 0, cyc_acc = 0, last_act = 0, last_len = 0;
    logic saw_start;

    task automatic cyc();
        #1;
        check(pwm_out === f_out(), "R3 pwm_out vs model", int'(pwm_out), int'(f_out()));
        check(period_start === f_last(), "R6 period_start vs model", int'(period_start), int'(f_last()));
        check(upd_pending === m_pend, "R7 upd_pending vs model", int'(upd_pending), int'(m_pend));
        saw_start = period_start;
        if (!en) begin
            act_acc = 0; cyc_acc = 0;
        end else if (period_start) begin
            last_act = act_acc + ((pwm_out == m_pol) ? 1 : 0);
            last_len = cyc_acc + 1;
            act_acc = 0; cyc_acc = 0;
        end else begin
            act_acc += (pwm_out == m_pol) ? 1 : 0;
            cyc_acc++;
        end
        @(negedge clk);
        cfg_wr = 1'b0;
        upd_wr = 1'b0;
    endtask

    task automatic configure(input int p, input int d, input int e, input logic pol);
        en = 1'b0;
        cfg_wr = 1'b1; cfg_period = W'(p); cfg_duty = W'(d);
        cfg_exp = 4'(e); cfg_pol = pol;
        cyc();
        cyc();
    endtask

    task automatic run_to_start(input int limit);
        for (int i = 0; i < limit; i++) begin
            cyc();
            if (saw_start) break;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        int seed_val;
        seed_val = int'($urandom(32'd20240611));
        @(negedge clk);
        cyc();
        cyc();
        // R1 reset state
        check(pwm_out == 1'b0, "R1 output low in reset", int'(pwm_out), 0);
        check(upd_pending == 1'b0, "R1 pending low in reset", int'(upd_pending), 0);
        check(period_start == 1'b0, "R1 no start in reset", int'(period_start), 0);
        rst = 1'b0;
        cyc();
        check(pwm_out == 1'b0, "R1 output low after reset", int'(pwm_out), 0);

        // R3 / R10 basic shape, full first period
        configure(8, 3, 0, 1'b1);
        en = 1'b1;
        run_to_start(100);
        check(last_len == 8, "R10 first period length", last_len, 8);
        check(last_act == 5, "R3 active cycles", last_act, 5);
        run_to_start(100);
        check(last_len == 8 && last_act == 5, "R3 second period", last_act, 5);

        // R2 exponent clamp: 13 behaves as 10
        configure(2, 1, 13, 1'b1);
        en = 1'b1;
        run_to_start(5000);
        check(last_len == 2048, "R2 clamped period length", last_len, 2048);
        check(last_act == 1024, "R2 clamped active part", last_act, 1024);

        // R4 polarity low-active
        configure(6, 2, 1, 1'b0);
        check(pwm_out == 1'b1, "R4 idle level for active-low", int'(pwm_out), 1);
        en = 1'b1;
        run_to_start(100);
        check(last_len == 12 && last_act == 8, "R4 active-low active cycles", last_act, 8);

        // R5 duty extremes
        configure(5, 0, 0, 1'b1);
        en = 1'b1;
        run_to_start(100);
        check(last_act == 5, "R5 duty zero full active", last_act, 5);
        configure(5, 9, 0, 1'b1);
        en = 1'b1;
        run_to_start(100);
        check(last_act == 0, "R5 duty above period never active", last_act, 0);

        // R8 mid-period duty change
        configure(8, 2, 1, 1'b1);
        en = 1'b1;
        repeat (6) cyc();
        upd_wr = 1'b1; upd_duty = W'(6);
        cyc();
        check(upd_pending == 1'b1, "R7 pending after update", int'(upd_pending), 1);
        run_to_start(100);
        check(last_act == 12, "R8 current period unchanged", last_act, 12);
        check(last_len == 16, "R8 current period length", last_len, 16);
        check(upd_pending == 1'b0, "R7 pending cleared at boundary", int'(upd_pending), 0);
        run_to_start(100);
        check(last_act == 4, "R7 new duty in next period", last_act, 4);

        // R9 configuration ignored while running, direct load while stopped
        configure(8, 3, 0, 1'b1);
        en = 1'b1;
        cyc();
        cfg_wr = 1'b1; cfg_period = W'(3); cfg_duty = W'(0);
        cyc();
        run_to_start(100);
        run_to_start(100);
        check(last_len == 8 && last_act == 5, "R9 config ignored while running", last_act, 5);
        en = 1'b0;
        upd_wr = 1'b1; upd_duty = W'(1);
        cyc();
        en = 1'b1;
        run_to_start(100);
        check(last_act == 7, "R9 direct duty load while stopped", last_act, 7);
        upd_wr = 1'b1; upd_duty = W'(6);
        cyc();
        en = 1'b0;
        cyc();
        check(upd_pending == 1'b0, "R9 pending cleared when stopped", int'(upd_pending), 0);
        en = 1'b1;
        run_to_start(100);
        check(last_act == 2, "R9 shadow applied when stopped", last_act, 2);

        // random phase against the model (R3, R6, R7, R9 compared every cycle)
        for (int it = 0; it < 40; it++) begin
            int p, d;
            p = 1 + int'($urandom_range(19));
            d = int'($urandom_range(p + 2));
            configure(p, d, int'($urandom_range(3)), 1'($urandom_range(1)));
            en = 1'b1;
            for (int c = 0; c < 60 + int'($urandom_range(200)); c++) begin
                if ($urandom_range(7) == 0) begin
                    upd_wr = 1'b1; upd_duty = W'($urandom_range(p + 2));
                end
                if ($urandom_range(15) == 0) begin
                    cfg_wr = 1'b1; cfg_period = W'($urandom_range(30));
                    cfg_duty = W'($urandom_range(30)); cfg_exp = 4'($urandom_range(15));
                end
                en = ($urandom_range(63) != 0);
                cyc();
                en = 1'b1;
            end
        end

        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule